// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator with Two-Thirds Prescale

This block derives the timing strobes for an asynchronous serial port from the system clock. A programmable reload value sets a down-counter that produces a 16x oversample tick. A four-bit phase counter then turns every sixteenth oversample tick into a bit tick. Before the counter sees the clock, a divide-by-two stage halves the rate. A single control input can also slow the clock by a further factor of two thirds. This lets a clock frequency that divides badly into the wanted rate land closer to it.

With the prescale off, the bit rate is f_clk / (32 x (reload + 1)). At 20 MHz a reload of 63 gives 9765.625 baud, 31 gives 19531.25 and 15 gives 39062.5. At 16 MHz, reloads of 51, 25 and 12 give roughly 9615, 19231 and 38461 baud. With the prescale on, the rate becomes f_clk / (48 x (reload + 1)).

Everything runs in one clock domain. The two-thirds factor is a clock-enable pattern produced by a three-state machine:
- `PS_PASS_A` always moves to `PS_PASS_B`.
- `PS_PASS_B` always moves to `PS_SWALLOW`.
- `PS_SWALLOW` returns to `PS_PASS_A`.
- When the prescale is off, the machine is forced to `PS_PASS_A` from any state, and every clock is passed.

The clock is enabled in both pass states and swallowed in `PS_SWALLOW`. The reload value is sampled only when the counter underflows, so it can be changed at any time without a stray tick.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, both `ovs_tick_o` and `bit_tick_o` are low.
- R2: With `prescale_en_i` low, consecutive rising `ovs_tick_o` pulses are exactly 2 x (reload + 1) clock cycles apart.
- R3: With `prescale_en_i` high, two of every three clocks reach the divider. Consecutive `ovs_tick_o` pulses are exactly 3 x (reload + 1) clock cycles apart.
- R4: `bit_tick_o` is high only in a cycle where `ovs_tick_o` is high. It appears on every sixteenth oversample tick, so bit ticks are 16 oversample periods apart.
- R5: A new `reload_i` value takes effect only at the next counter underflow. The interval in progress when the value changes completes with the old value, the following interval uses the new one, and no shorter interval appears.
- R6: Each `ovs_tick_o` pulse lasts exactly one clock cycle.
- R7: A reload value of 0 gives the fastest rate: an oversample tick every 2 cycles without the prescale and every 3 cycles with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_i | input | RELOAD_W | Divider reload value; the counter period is reload + 1 enabled steps |
| prescale_en_i | input | 1 | High inserts the two-thirds clock-enable prescale |
| ovs_tick_o | output | 1 | One-cycle 16x oversample tick |
| bit_tick_o | output | 1 | One-cycle bit tick, coincident with every sixteenth oversample tick |

## Verification
The bench sweeps every small reload value and a few larger ones in both prescale modes, and compares the measured tick spacing with 2(R+1) or 3(R+1) computed from the formula.
- Reload 0 is the sharpest corner. A counter that underflowed at the wrong count, or a divide-by-two stage that skipped a phase, would show up there as an interval of 1 or 4 instead of 2 or 3.
- A prescaler that swallowed the wrong share of clocks would stretch intervals by a fraction other than one half.
- The bench changes the reload value just after an underflow. A design that loaded the value immediately would shorten the interval in progress or emit an early tick.
- Bit ticks are timed against 16 oversample periods and watched for any cycle in which they appear without an oversample tick.

// File: rtl/baud_pkg.sv
package baud_pkg;

    // Clock-enable pattern states for the two-thirds prescale
    typedef enum logic [1:0] {
        PS_PASS_A  = 2'd0,
        PS_PASS_B  = 2'd1,
        PS_SWALLOW = 2'd2
    } ps_state_t;

    localparam int unsigned OVS_PER_BIT = 16;

endpackage

// File: rtl/baud_prescale.sv
module baud_prescale
    import baud_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic prescale_en_i,
    output logic en_o
);

    ps_state_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = PS_PASS_A;
        unique case (state_q)
            PS_PASS_A:  state_d = PS_PASS_B;
            PS_PASS_B:  state_d = PS_SWALLOW;
            PS_SWALLOW: state_d = PS_PASS_A;
            default:    state_d = PS_PASS_A;
        endcase
        if (!prescale_en_i) begin
            state_d = PS_PASS_A;
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PS_PASS_A;
        end else begin
            state_q <= state_d;
        end
    end

    // output decode: one clock in three is swallowed when enabled
    always_comb begin
        en_o = 1'b1;
        unique case (state_q)
            PS_PASS_A:  en_o = 1'b1;
            PS_PASS_B:  en_o = 1'b1;
            PS_SWALLOW: en_o = !prescale_en_i;
            default:    en_o = 1'b1;
        endcase
    end

    // R3: after two passed clocks in a row under prescale, the next is swallowed
    a_r3_swallow_third: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prescale_en_i && $past(prescale_en_i) && en_o && $past(en_o))
            |=> (!prescale_en_i || !en_o));

    // R3: a swallowed clock is never followed by another swallowed clock
    a_r3_no_double_swallow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_o |=> en_o);

endmodule

// File: rtl/baud_reload_ctr.sv
module baud_reload_ctr #(
    parameter int unsigned RELOAD_W = 13
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                en_i,
    input  logic [RELOAD_W-1:0] reload_i,
    output logic                ovs_tick_o
);

    logic                half_q;
    logic [RELOAD_W-1:0] cnt_q;
    logic                ovs_q;
    logic                step;
    logic                underflow;

    // divide-by-two stage feeding the reload counter
    assign step      = en_i && half_q;
    assign underflow = step && (cnt_q == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            half_q <= 1'b0;
            cnt_q  <= '0;
            ovs_q  <= 1'b0;
        end else begin
            if (en_i) begin
                half_q <= !half_q;
            end
            if (underflow) begin
                cnt_q <= reload_i;        // reload value sampled only here
            end else if (step) begin
                cnt_q <= cnt_q - 1'b1;
            end
            ovs_q <= underflow;
        end
    end

    assign ovs_tick_o = ovs_q;

    // R2: counter steps down by one on every non-underflow step
    a_r2_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5: outside underflow the counter never picks up a new reload value
    a_r5_hold_between_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step |=> $stable(cnt_q));

    // R6: oversample tick is a single-cycle pulse
    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovs_q |=> !ovs_q);

endmodule

// File: rtl/baud_bit_ctr.sv
module baud_bit_ctr #(
    parameter int unsigned OVS = baud_pkg::OVS_PER_BIT
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ovs_tick_i,
    output logic bit_tick_o
);

    localparam int unsigned IW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [IW-1:0] LAST = IW'(OVS - 1);

    logic [IW-1:0] idx_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            idx_q <= '0;
        end else if (ovs_tick_i) begin
            if (idx_q == LAST) begin
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign bit_tick_o = ovs_tick_i && (idx_q == LAST);

    // R4: phase counter only moves on an oversample tick
    a_r4_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ovs_tick_i |=> $stable(idx_q));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int unsigned RELOAD_W = 13,
    parameter int unsigned OVS      = OVS_PER_BIT
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [RELOAD_W-1:0] reload_i,
    input  logic                prescale_en_i,
    output logic                ovs_tick_o,
    output logic                bit_tick_o
);

    logic clk_en;

    baud_prescale u_prescale (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .prescale_en_i (prescale_en_i),
        .en_o          (clk_en)
    );

    baud_reload_ctr #(
        .RELOAD_W (RELOAD_W)
    ) u_reload_ctr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (clk_en),
        .reload_i   (reload_i),
        .ovs_tick_o (ovs_tick_o)
    );

    baud_bit_ctr #(
        .OVS (OVS)
    ) u_bit_ctr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ovs_tick_i (ovs_tick_o),
        .bit_tick_o (bit_tick_o)
    );

    // R4: a bit tick always coincides with an oversample tick
    a_r4_bit_on_ovs: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_tick_o |-> ovs_tick_o);

    // R6: bit tick is a single-cycle pulse
    a_r6_bit_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_tick_o |=> !bit_tick_o);

endmodule

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;

    localparam int RW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] reload = '0;
    logic          pre_en = 1'b0;
    logic          ovs;
    logic          bitt;

    int checks = 0;
    int fails  = 0;
    int orphan = 0;

    always #2.5 clk = ~clk;

    baud_tick_gen #(.RELOAD_W(RW)) u_baud_tick_gen (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .reload_i      (reload),
        .prescale_en_i (pre_en),
        .ovs_tick_o    (ovs),
        .bit_tick_o    (bitt)
    );

    // R4 monitor: a bit tick without an oversample tick
    always @(negedge clk) begin
        if (rst_n && bitt && !ovs) orphan++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic next_ovs(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ovs && n < 100000);
    endtask

    task automatic next_bit(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bitt && n < 100000);
    endtask

    task automatic run_cfg(input int r, input bit m);
        int n;
        @(negedge clk);
        reload = RW'(r);
        pre_en = m;
        for (int k = 0; k < 3; k++) next_ovs(n);
        for (int k = 0; k < 2; k++) begin
            next_ovs(n);
            if (r == 0) check("R7", n, m ? 3 : 2);
            else        check(m ? "R3" : "R2", n, (m ? 3 : 2) * (r + 1));
        end
    endtask

    task automatic bit_cfg(input int r, input bit m);
        int n;
        @(negedge clk);
        reload = RW'(r);
        pre_en = m;
        for (int k = 0; k < 2; k++) next_bit(n);
        next_bit(n);
        check("R4", n, 16 * (m ? 3 : 2) * (r + 1));
    endtask

    task automatic change_cfg(input int r_old, input int r_new, input bit m);
        int n;
        @(negedge clk);
        reload = RW'(r_old);
        pre_en = m;
        for (int k = 0; k < 4; k++) next_ovs(n);
        reload = RW'(r_new);             // just after an underflow
        next_ovs(n);
        check("R5 old interval", n, (m ? 3 : 2) * (r_old + 1));
        next_ovs(n);
        check("R5 new interval", n, (m ? 3 : 2) * (r_new + 1));
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int quiet;
        int n;
        quiet = 0;
        // R1: outputs low through reset, with a short reload
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (ovs || bitt) quiet++;
        end
        check("R1", quiet, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R3 / R7 sweeps
        for (int m = 0; m < 2; m++) begin
            for (int r = 0; r <= 12; r++) run_cfg(r, m[0]);
            run_cfg(15, m[0]);
            run_cfg(31, m[0]);
            run_cfg(63, m[0]);
        end

        // R6: pulse width of the oversample tick at the fastest rate
        @(negedge clk);
        reload = '0;
        pre_en = 1'b0;
        next_ovs(n);
        next_ovs(n);
        @(negedge clk);
        check("R6", int'(ovs), 0);

        // R4: bit tick spacing
        bit_cfg(0, 1'b0);
        bit_cfg(2, 1'b0);
        bit_cfg(0, 1'b1);
        bit_cfg(2, 1'b1);

        // R5: reload change mid-interval
        change_cfg(5, 9, 1'b0);
        change_cfg(9, 2, 1'b1);
        change_cfg(12, 0, 1'b0);

        check("R4 orphan bit ticks", orphan, 0);
        summary();
        $finish;
    end

endmodule